// File: doc/BRIEF.md
# Link Integrity Check Frame Scheduler

This block counts video frames and tells a content-protection engine when to act. A single-cycle frame-start strobe advances the count. At fixed frame boundaries the block raises one-clock strobes. One strobe asks for a short-period integrity value. Another asks for a long-period value. Two more ask for the long-period value to be compared: a pre-check one frame ahead of the boundary, and the main check on the boundary frame. The pre-check confirms that transmitter and receiver still agree on frame numbering before the boundary is reached. The block does not compute any cipher, does not compare any value and does not reach the receiver over any bus.

Scheduling runs only while `link_en` (authenticated) is high. Dropping it clears the count. Counting then resumes from the first frame-start after it rises again. A fast mode divides both periods by eight so the sequence can be exercised quickly. A change of mode is picked up only while the count is at zero, so a period that is under way always finishes with its original length. A separate control masks the pre-check.

Top module: `link_chk_sched`

## Requirements
- R1: After reset, and in every cycle after a clock edge at which `link_en` was low, all four strobes are low and the frame count is zero. The first frame-start accepted after `link_en` rises counts as frame 1.
- R2: In normal mode (`fast_mode` = 0), `short_calc` pulses on every frame whose number is a multiple of 16 (frames 16, 32, ... 128).
- R3: In normal mode, `long_calc` and `long_chk` both pulse on frame 128. The count then wraps, so the next frame is frame 1 again.
- R4: When `sync_chk_off` is 0 on the frame-start of the frame just before the boundary (frame 127 in normal mode), `long_prechk` pulses for that frame.
- R5: When `sync_chk_off` is 1 on that frame-start, `long_prechk` stays low. `long_calc` and `long_chk` still pulse on the boundary frame.
- R6: In fast mode (`fast_mode` = 1), `short_calc` pulses every 2 frames. `long_calc` and `long_chk` pulse on frame 16, and the pre-check falls on frame 15.
- R7: `fast_mode` is sampled only in cycles when the count is zero (idle, or right after a wrap). The mode held from then on governs the whole period until the next wrap, whatever `fast_mode` does meanwhile.
- R8: Each strobe is exactly one clock wide and is high in the cycle right after the clock edge at which `frame_start` was sampled high. No strobe appears without such a frame-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of each video frame |
| link_en | input | 1 | Authenticated; scheduling runs only while high |
| fast_mode | input | 1 | 1 selects the periods divided by eight |
| sync_chk_off | input | 1 | 1 masks the pre-boundary check strobe |
| short_calc | output | 1 | Compute the short-period value |
| long_calc | output | 1 | Compute the long-period value |
| long_prechk | output | 1 | Synchronization check one frame before the boundary |
| long_chk | output | 1 | Long-period check on the boundary frame |

## Verification
The assertions rely on `frame_start` being a single-cycle pulse with at least one idle cycle between pulses. They also rely on both periods being at least two frames long. The one-clock-wide and no-back-to-back properties depend on these input conditions. The stimulus raises `frame_start` for one cycle in every four and changes `link_en`, `fast_mode` and `sync_chk_off` only away from the clock edge. It also toggles `fast_mode` in the middle of a period to exercise the deferred mode switch.

// File: rtl/link_chk_sched.sv
module link_chk_sched #(
  parameter int SHORT_LOG   = 4,
  parameter int LONG_LOG    = 7,
  parameter int SPEEDUP_LOG = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic link_en,
  input  logic fast_mode,
  input  logic sync_chk_off,
  output logic short_calc,
  output logic long_calc,
  output logic long_prechk,
  output logic long_chk
);
  localparam int CW = LONG_LOG;
  localparam logic [CW-1:0] L_NORM = CW'((1 << LONG_LOG) - 1);
  localparam logic [CW-1:0] L_FAST = CW'((1 << (LONG_LOG - SPEEDUP_LOG)) - 1);
  localparam logic [CW-1:0] S_NORM = CW'((1 << SHORT_LOG) - 1);
  localparam logic [CW-1:0] S_FAST = CW'((1 << (SHORT_LOG - SPEEDUP_LOG)) - 1);

  logic [CW-1:0] cnt;
  logic          mode_q;

  wire           idle     = (cnt == '0);
  wire           mode_eff = idle ? fast_mode : mode_q;
  wire [CW-1:0]  last     = mode_eff ? L_FAST : L_NORM;
  wire [CW-1:0]  smask    = mode_eff ? S_FAST : S_NORM;
  wire           hit      = frame_start & link_en;
  wire           at_end   = (cnt == last);
  wire           at_pre   = (cnt == last - CW'(1));
  wire           at_short = ((cnt & smask) == smask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      mode_q      <= 1'b0;
      short_calc  <= 1'b0;
      long_calc   <= 1'b0;
      long_prechk <= 1'b0;
      long_chk    <= 1'b0;
    end else if (!link_en) begin
      cnt         <= '0;
      mode_q      <= 1'b0;
      short_calc  <= 1'b0;
      long_calc   <= 1'b0;
      long_prechk <= 1'b0;
      long_chk    <= 1'b0;
    end else begin
      mode_q      <= mode_eff;
      short_calc  <= hit & at_short;
      long_calc   <= hit & at_end;
      long_chk    <= hit & at_end;
      long_prechk <= hit & at_pre & ~sync_chk_off;
      if (hit) cnt <= at_end ? '0 : cnt + CW'(1);
    end
  end
endmodule

module link_chk_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic link_en,
  input logic sync_chk_off,
  input logic short_calc,
  input logic long_calc,
  input logic long_prechk,
  input logic long_chk
);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> !(short_calc | long_calc | long_prechk | long_chk));
  p_chk_with_calc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    long_chk == long_calc);
  p_long_on_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
    long_calc |-> short_calc);
  p_pre_not_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(long_prechk && long_calc));
  p_pre_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    long_prechk |-> $past(!sync_chk_off));
  p_after_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (short_calc | long_calc | long_prechk) |-> $past(frame_start && link_en));
  p_one_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (short_calc | long_calc | long_prechk) |=> !(short_calc | long_calc | long_prechk));
endmodule

bind link_chk_sched link_chk_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .link_en(link_en),
  .sync_chk_off(sync_chk_off), .short_calc(short_calc), .long_calc(long_calc),
  .long_prechk(long_prechk), .long_chk(long_chk)
);

// File: tb/sim_link_chk_sched.sv
module sim_link_chk_sched;
  logic clk = 0, rst_n = 0, frame_start = 0, link_en = 0, fast_mode = 0, sync_chk_off = 0;
  logic short_calc, long_calc, long_prechk, long_chk;
  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  link_chk_sched u0 (.*);

  always #4 clk = ~clk;

  // behavioural reference
  int  m_cnt = 0;
  bit  m_mode = 0;
  bit  e_s = 0, e_l = 0, e_p = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !link_en) begin
      m_cnt = 0; m_mode = 0; e_s = 0; e_l = 0; e_p = 0;
    end else begin
      bit cur;
      int lp, sp, f;
      cur = (m_cnt == 0) ? fast_mode : m_mode;
      m_mode = cur;
      lp = cur ? 16 : 128;
      sp = cur ? 2 : 16;
      e_s = 0; e_l = 0; e_p = 0;
      if (frame_start) begin
        f = m_cnt + 1;
        e_s = (f % sp) == 0;
        e_l = (f == lp);
        e_p = (f == lp - 1) && !sync_chk_off;
        m_cnt = e_l ? 0 : f;
      end
    end
  end

  int n_s = 0, n_l = 0, n_p = 0;
  task automatic cmp(input string nm, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp("short_calc", short_calc, e_s);
    cmp("long_calc", long_calc, e_l);
    cmp("long_prechk", long_prechk, e_p);
    cmp("long_chk", long_chk, e_l);
    n_s += short_calc; n_l += long_calc; n_p += long_prechk;
  end

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_start = 1;
      @(negedge clk) frame_start = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic expect_n(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s count act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clr; n_s = 0; n_l = 0; n_p = 0; endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_n("R1", short_calc + long_calc + long_prechk + long_chk, 0);
    rst_n = 1;
    // R1: disabled, frames ignored
    clr; frames(20);
    expect_n("R1", n_s + n_l + n_p, 0);
    // R2 R3 R4 R8: normal mode, two full periods
    tag = "R2 R3 R4 R8"; link_en = 1; clr; frames(256);
    expect_n("R2", n_s, 16);
    expect_n("R3", n_l, 2);
    expect_n("R4", n_p, 2);
    // R5: pre-check masked
    tag = "R5"; sync_chk_off = 1; clr; frames(128);
    expect_n("R5", n_p, 0);
    expect_n("R5", n_l, 1);
    sync_chk_off = 0;
    // R7: switch to fast mid-period; period stays 128
    tag = "R7"; clr; frames(40); fast_mode = 1; frames(88);
    expect_n("R7", n_l, 1);
    expect_n("R7", n_s, 8);
    // R6: fast mode now in force
    tag = "R6"; clr; frames(32);
    expect_n("R6", n_s, 16);
    expect_n("R6", n_l, 2);
    expect_n("R6", n_p, 2);
    // R7: back to normal mid fast period; fast period finishes
    tag = "R7"; clr; frames(5); fast_mode = 0; frames(11);
    expect_n("R7", n_l, 1);
    // R1: drop enable mid-period, restart from frame 1
    tag = "R1"; frames(50); link_en = 0; frames(3); link_en = 1; clr; frames(127);
    expect_n("R1", n_l, 0);
    expect_n("R1", n_p, 1);
    frames(1);
    expect_n("R1", n_l, 1);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule